// File: doc/BRIEF.md
# Multicore Spin Table Release Controller

This block is a small register window that boot software uses to start secondary processor cores. Each core index owns a 32-byte record in the window. The record holds a 64-bit start address at byte offset 0, a 64-bit argument at offset 8, a 32-bit spare word at offset 16, a 32-bit core identity word at offset 20 and a 64-bit spare doubleword at offset 24. The window is accessed through a simple byte-addressed bus. Data is big-endian, and transfers are 1, 2 or 4 bytes wide. The record index is the byte address divided by 32.

After reset, every start address holds the value 1, which parks the core. When an accepted write leaves bit 0 of a record's start address at zero, the block emits a one-cycle release pulse. The pulse carries the core index, the entry point inside a 2^MAP_BITS-byte window, the base of that window and the argument word. On the clock edge that ends the pulse, the block stores the core's real hardware identity in the record's identity word. Record 0 belongs to the primary core, and software cannot write it. Records at or above CORE_COUNT have no core behind them and are also write-protected.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, record i holds start address 1, argument i and identity word i; both spare fields read 0; rel_valid, rd_err and rdata are 0.
- R2: A write with size code 1, 2 or 4 stores that many bytes starting at addr. The lowest address receives the most significant byte of the low `size` bytes of wdata.
- R3: A read with size code 1, 2 or 4 returns the bytes starting at addr, right-justified in rdata, with the lowest address as the most significant byte. The result appears in the cycle after rd_en and rd_err is 0. Any other size code sets rd_err and returns rdata 0.
- R4: Writes to record 0 and to records at or above CORE_COUNT store nothing and produce no release.
- R5: In the cycle after an accepted write, rel_valid is high for exactly one cycle if bit 0 of that record's start address (byte offset 7, bit 0) is then 0, and rel_core gives the record index. If that bit is 1, no pulse occurs.
- R6: During a pulse, rel_entry is the start address AND (2^MAP_BITS - 1), and rel_map_base is the start address with its low MAP_BITS bits cleared. rel_map_size is 2^MAP_BITS and rel_arg is the record's argument word unchanged.
- R7: On the edge that ends a pulse, the record's identity word (offsets 20..23) takes the value hw_id[32*core +: 32].
- R8: Each further accepted write to a record whose bit 0 is still 0 gives another pulse, whichever byte of the record it touches.
- R9: If a bus write falls on the same edge as an identity-word update, the bytes written by the bus take precedence.
- R10: Reads may target any record, including record 0 and records with no core.
- R11: An accepted write with a size code other than 1, 2 or 4 stores nothing but still performs the release check of R5.

Port table. CW is CORE_COUNT*32, AW is log2(NUM_ENTRIES*32) and IW is log2(NUM_ENTRIES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address in the window |
| size | input | 3 | Transfer size in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, right-justified |
| rdata | output | 32 | Read data, right-justified, one cycle after rd_en |
| rd_err | output | 1 | Last read used an invalid size |
| hw_id | input | CW | Hardware identity of each core, 32 bits per core |
| rel_valid | output | 1 | Release pulse |
| rel_core | output | IW | Index of the released core |
| rel_entry | output | 64 | Entry point inside the mapping |
| rel_arg | output | 64 | Argument word |
| rel_map_base | output | 64 | Base of the initial mapping |
| rel_map_size | output | 64 | Size of the initial mapping |

## Verification
The identity-word update from a release and a fresh bus write to the same record can land on the same clock edge. The bench provokes this by issuing a second write to the released core's identity word in the very next cycle after the releasing write. It then reads the word back to back, which returns the bus value rather than the hardware identity. The second write also releases the core again, so one idle cycle later a further read returns the hardware identity. This sequence separates bus-wins, hardware-wins and lost-update behaviour.

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl #(
  parameter int CORE_COUNT  = 32,
  parameter int NUM_ENTRIES = 32,
  parameter int MAP_BITS    = 26,
  localparam int REC_BYTES = 32,
  localparam int WIN_BYTES = NUM_ENTRIES * REC_BYTES,
  localparam int AW        = $clog2(WIN_BYTES),
  localparam int IW        = $clog2(NUM_ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [2:0]              size,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    rd_err,
  input  logic [CORE_COUNT*32-1:0] hw_id,
  output logic                    rel_valid,
  output logic [IW-1:0]           rel_core,
  output logic [63:0]             rel_entry,
  output logic [63:0]             rel_arg,
  output logic [63:0]             rel_map_base,
  output logic [63:0]             rel_map_size
);

  localparam logic [63:0] MAP_MASK = (64'd1 << MAP_BITS) - 64'd1;

  logic [7:0]    mem [WIN_BYTES];
  logic          pend_vld;
  logic [IW-1:0] pend_idx;
  logic [2:0]    nb;
  logic [31:0]   wr_lj, rd_lj, rd_rj, pick;
  logic [63:0]   rec_addr;

  wire [IW-1:0] wr_idx = addr[AW-1:5];
  wire          wr_ok  = wr_en && (wr_idx != '0) && (32'(wr_idx) < CORE_COUNT);
  wire [AW-1:0] pbase  = AW'({pend_idx, 5'd0});

  always_comb begin
    case (size)
      3'd1, 3'd2, 3'd4: nb = size;
      default:          nb = 3'd0;
    endcase
    case (nb)
      3'd1:    wr_lj = {wdata[7:0], 24'd0};
      3'd2:    wr_lj = {wdata[15:0], 16'd0};
      default: wr_lj = wdata;
    endcase
    rd_lj = {mem[addr], mem[addr + AW'(1)], mem[addr + AW'(2)], mem[addr + AW'(3)]};
    case (nb)
      3'd1:    rd_rj = {24'd0, rd_lj[31:24]};
      3'd2:    rd_rj = {16'd0, rd_lj[31:16]};
      3'd4:    rd_rj = rd_lj;
      default: rd_rj = 32'd0;
    endcase
  end

  always_comb begin
    rec_addr = '0;
    rel_arg  = '0;
    for (int k = 0; k < 8; k++) begin
      rec_addr = {rec_addr[55:0], mem[pbase + AW'(k)]};
      rel_arg  = {rel_arg[55:0],  mem[pbase + AW'(8 + k)]};
    end
    pick = '0;
    for (int c = 0; c < CORE_COUNT; c++)
      if (32'(pend_idx) == c) pick = hw_id[c*32 +: 32];
  end

  assign rel_valid    = pend_vld && !rec_addr[0];
  assign rel_core     = pend_idx;
  assign rel_entry    = rec_addr & MAP_MASK;
  assign rel_map_base = rec_addr & ~MAP_MASK;
  assign rel_map_size = 64'd1 << MAP_BITS;

  function automatic logic [7:0] rst_byte(int e, int b);
    case (b)
      7:       return 8'd1;
      15, 23:  return 8'(e);
      default: return 8'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++)
        for (int b = 0; b < REC_BYTES; b++)
          mem[e*REC_BYTES + b] <= rst_byte(e, b);
      pend_vld <= 1'b0;
      pend_idx <= '0;
      rdata    <= '0;
      rd_err   <= 1'b0;
    end else begin
      pend_vld <= wr_ok;
      pend_idx <= wr_idx;
      if (rel_valid)
        for (int k = 0; k < 4; k++)
          mem[pbase + AW'(20 + k)] <= pick[31 - 8*k -: 8];
      if (wr_ok)
        for (int k = 0; k < 4; k++)
          if (3'(k) < nb) mem[addr + AW'(k)] <= wr_lj[31 - 8*k -: 8];
      if (rd_en) begin
        rdata  <= rd_rj;
        rd_err <= (nb == 3'd0);
      end
    end
  end

  // R5
  a_r5_release_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> ($past(wr_en) && $past(wr_idx) == rel_core));

  // R4
  a_r4_release_core_present: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_core != '0 && 32'(rel_core) < CORE_COUNT));

  // R6
  a_r6_entry_inside_map: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_entry < rel_map_size && !rel_entry[0]));

  // R3
  a_r3_bad_size_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size != 3'd1 && size != 3'd2 && size != 3'd4) |=> (rd_err && rdata == 32'd0));

  // R7
  a_r7_id_written: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rel_valid) && !$past(wr_en)) |->
      {mem[AW'({$past(rel_core), 5'd20})], mem[AW'({$past(rel_core), 5'd21})],
       mem[AW'({$past(rel_core), 5'd22})], mem[AW'({$past(rel_core), 5'd23})]} == $past(pick));

endmodule

// File: tb/tb_spin_release_ctrl.sv
module tb_spin_release_ctrl;
  localparam int PERIOD = 10;
  localparam int CORES  = 6;
  localparam int NV     = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [9:0] addr = 0;
  logic [2:0] size = 0;
  logic [31:0] wdata = 0, rdata;
  logic rd_err, rel_valid;
  logic [CORES*32-1:0] hw_id;
  logic [4:0] rel_core;
  logic [63:0] rel_entry, rel_arg, rel_map_base, rel_map_size;

  int checks = 0, fails = 0;
  logic        c_vld;
  logic [4:0]  c_core;
  logic [63:0] c_entry, c_arg, c_base, c_msize;
  logic [31:0] c_rdata;
  logic        c_err;

  spin_release_ctrl #(.CORE_COUNT(CORES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata), .rd_err(rd_err), .hw_id(hw_id), .rel_valid(rel_valid),
    .rel_core(rel_core), .rel_entry(rel_entry), .rel_arg(rel_arg),
    .rel_map_base(rel_map_base), .rel_map_size(rel_map_size));

  always #(PERIOD/2) clk = ~clk;

  // op: 0 write no release, 2 read; fields {op, addr, size, data, expected}
  localparam logic [78:0] VEC [NV] = '{
    {2'd2, 10'h074, 3'd4, 32'h0, 32'd3},          // R1 core3 id
    {2'd2, 10'h06C, 3'd4, 32'h0, 32'd3},          // R1 core3 arg low
    {2'd2, 10'h068, 3'd4, 32'h0, 32'd0},          // R1 core3 arg high
    {2'd2, 10'h044, 3'd4, 32'h0, 32'd1},          // R1 core2 addr low
    {2'd2, 10'h007, 3'd1, 32'h0, 32'd1},          // R10 record 0
    {2'd2, 10'h3F4, 3'd4, 32'h0, 32'd31},         // R10 record 31
    {2'd0, 10'h048, 3'd4, 32'h12345678, 32'h0},   // R2
    {2'd2, 10'h048, 3'd4, 32'h0, 32'h12345678},   // R3
    {2'd2, 10'h048, 3'd2, 32'h0, 32'h1234},       // R3
    {2'd2, 10'h04B, 3'd1, 32'h0, 32'h78},         // R3
    {2'd0, 10'h04A, 3'd2, 32'hFFFFBEEF, 32'h0},   // R2
    {2'd2, 10'h048, 3'd4, 32'h0, 32'h1234BEEF},   // R2
    {2'd0, 10'h004, 3'd4, 32'h0, 32'h0},          // R4 record 0
    {2'd2, 10'h004, 3'd4, 32'h0, 32'd1},          // R4
    {2'd0, 10'h0E4, 3'd4, 32'h0, 32'h0},          // R4 absent core 7
    {2'd2, 10'h0E4, 3'd4, 32'h0, 32'd1}           // R4
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [2:0] s, input logic [31:0] d);
    wr_en = 1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 0;
    c_vld = rel_valid; c_core = rel_core; c_entry = rel_entry;
    c_arg = rel_arg; c_base = rel_map_base; c_msize = rel_map_size;
  endtask

  task automatic rd(input logic [9:0] a, input logic [2:0] s);
    rd_en = 1; addr = a; size = s;
    @(negedge clk);
    rd_en = 0;
    c_rdata = rdata; c_err = rd_err;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < CORES; c++) hw_id[c*32 +: 32] = 32'hC0DE0000 + c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rel_valid == 0, "R1 rel_valid", 64'(rel_valid), 0);
    chk(rd_err == 0 && rdata == 0, "R1 read outputs", 64'(rdata), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][78:77] == 2'd2) begin
        rd(VEC[i][76:67], VEC[i][66:64]);
        chk(c_rdata == VEC[i][31:0] && !c_err, $sformatf("R3 vector %0d", i), 64'(c_rdata), 64'(VEC[i][31:0]));
      end else begin
        wr(VEC[i][76:67], VEC[i][66:64], VEC[i][63:32]);
        chk(!c_vld, $sformatf("R4 vector %0d no release", i), 64'(c_vld), 0);
      end
      idle();
    end

    // R5 R6 R7
    wr(10'h040, 3'd4, 32'h00000001);
    chk(!c_vld, "R5 bit0 set no release", 64'(c_vld), 0);
    idle();
    wr(10'h044, 3'd4, 32'h0BC00100);
    chk(c_vld && c_core == 2, "R5 release core2", 64'(c_core), 2);
    chk(c_entry == 64'h03C00100, "R6 entry", c_entry, 64'h03C00100);
    chk(c_base == 64'h1_08000000, "R6 map base", c_base, 64'h1_08000000);
    chk(c_arg == 64'h1234BEEF_00000002, "R6 arg", c_arg, 64'h1234BEEF_00000002);
    chk(c_msize == 64'h4000000, "R6 map size", c_msize, 64'h4000000);
    idle();
    chk(rel_valid == 0, "R5 single cycle", 64'(rel_valid), 0);
    rd(10'h054, 3'd4);
    chk(c_rdata == 32'hC0DE0002, "R7 id overwrite", 64'(c_rdata), 64'hC0DE0002);
    idle();

    // R8
    wr(10'h050, 3'd2, 32'h0000ABCD);
    chk(c_vld && c_core == 2, "R8 repeat release", 64'(c_vld), 1);
    idle();

    // R3 invalid size read
    rd(10'h044, 3'd3);
    chk(c_err && c_rdata == 0, "R3 bad size", 64'(c_rdata), 0);
    rd(10'h044, 3'd4);
    chk(!c_err && c_rdata == 32'h0BC00100, "R3 good size after bad", 64'(c_rdata), 64'h0BC00100);
    idle();

    // R11
    wr(10'h084, 3'd3, 32'h0);
    chk(!c_vld, "R11 bad size write no release", 64'(c_vld), 0);
    idle();
    rd(10'h084, 3'd4);
    chk(c_rdata == 1, "R11 bad size write stores nothing", 64'(c_rdata), 1);
    idle();
    wr(10'h087, 3'd1, 32'h0);
    chk(c_vld && c_core == 4 && c_entry == 0, "R5 release core4", c_entry, 0);
    idle();
    wr(10'h080, 3'd0, 32'hFFFFFFFF);
    chk(c_vld && c_core == 4, "R11 bad size write still releases", 64'(c_vld), 1);
    idle();
    rd(10'h080, 3'd4);
    chk(c_rdata == 0, "R11 no store", 64'(c_rdata), 0);
    idle();

    // R9 collision on last present core
    wr(10'h0A7, 3'd1, 32'h0);
    chk(c_vld && c_core == 5, "R4 last core releases", 64'(c_core), 5);
    wr(10'h0B4, 3'd4, 32'h55AA55AA);
    chk(c_vld && c_core == 5, "R8 back-to-back release", 64'(c_vld), 1);
    rd(10'h0B4, 3'd4);
    chk(c_rdata == 32'h55AA55AA, "R9 bus write wins", 64'(c_rdata), 64'h55AA55AA);
    idle();
    rd(10'h0B4, 3'd4);
    chk(c_rdata == 32'hC0DE0005, "R7 id after second release", 64'(c_rdata), 64'hC0DE0005);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule